// File: doc/BRIEF.md
# Packed Half-Precision to Unsigned Integer Converter

This block turns a vector of up to sixteen IEEE half-precision values into 32-bit unsigned integers, one lane per element, and writes the lanes into a registered destination vector. A per-lane write mask decides which lanes take a converted value. An unselected lane either keeps the old destination word that comes in with the operation or is forced to zero. A broadcast option makes every lane convert element 0 when the operand comes from memory. The rounding mode normally comes from a global control field. An override field replaces it only for a full-width register-sourced operation with the broadcast/override bit set.

Each operation is presented for one cycle with `in_valid`. The result word and two sticky-free status flags (invalid, inexact) appear together one cycle later with `out_valid`, and they hold until the next operation. A value that cannot be held in an unsigned 32-bit integer returns the all-ones indefinite value and raises the invalid flag.

Top module: `hcvt_u32_top`

## Requirements
- R1: `vlen_sel` picks the number of active lanes: 0 selects 4 lanes, 1 selects 8 lanes, and 2 or 3 select 16 lanes. Lane j occupies bits [32j+31:32j] of `dst` and reads bits [16j+15:16j] of `src_vec`.
- R2: Under round-to-nearest-even, a finite non-negative half value converts to its nearest integer. An exact tie goes to the even integer. Non-integer inputs raise `flag_inexact`.
- R3: The rounding encoding is 0 = nearest even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. Each mode is applied to inexact inputs.
- R4: `rc_override` is used only when `src_is_mem`=0, `vlen_sel` selects 16 lanes and `bcast_rc`=1. In every other case `rc_global` is used.
- R5: When `src_is_mem`=1 and `bcast_rc`=1, every lane converts element 0 of `src_vec`. With a register source, `bcast_rc` causes no broadcast.
- R6: With `mask_en`=1 and `zero_en`=0, an active lane whose `lane_mask` bit is 0 takes its word from `old_dst`.
- R7: With `mask_en`=1 and `zero_en`=1, an active lane whose `lane_mask` bit is 0 becomes zero. With `mask_en`=0, every active lane is written.
- R8: Destination lanes at or above the active lane count are zero, whatever `old_dst` holds.
- R9: Infinities, NaNs, and negative inputs whose rounded value is below zero give 0xFFFFFFFF and raise `flag_invalid` without `flag_inexact`.
- R10: A negative input that rounds to zero gives 0 without `flag_invalid`. It raises `flag_inexact` only if it was not already zero.
- R11: The flags are the OR over active, written lanes only. Masked-off and inactive lanes never set them.
- R12: Reset clears `dst`, the flags and `out_valid`. `out_valid` is `in_valid` delayed one cycle. `dst` and the flags load only on `in_valid` and hold otherwise.
- R13: Subnormal inputs are converted, and they round to 0 or 1 according to the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 256 | Packed half-precision source elements |
| old_dst | input | 512 | Previous destination contents, used for merging |
| lane_mask | input | 16 | Per-lane write enables |
| mask_en | input | 1 | Apply `lane_mask` when 1 |
| zero_en | input | 1 | Zero masked-off lanes instead of merging |
| vlen_sel | input | 2 | Vector length select |
| bcast_rc | input | 1 | Broadcast (memory source) / rounding override (register source) |
| src_is_mem | input | 1 | Source operand came from memory |
| rc_override | input | 2 | Per-operation rounding mode |
| rc_global | input | 2 | Global rounding mode |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dst | output | 512 | Registered destination vector |
| flag_invalid | output | 1 | Invalid-operation status |
| flag_inexact | output | 1 | Precision status |

## Verification
Internal faults surface one cycle after the operation strobe, because every lane and flag is registered once. A wrong lane-count decode shows as nonzero or converted words above the active length. A wrong rounding selector shows as an off-by-one result in exactly the lanes fed with halfway or fractional values. A flag mis-gated by the mask shows as a raised flag while every visible lane holds an ordinary value. A broken load enable shows as the destination drifting in a cycle with no strobe.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
   localparam int HALF_W = 16;
   localparam int INT_W  = 32;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;

   typedef struct packed {
      logic [INT_W-1:0] value;
      logic             inv;
      logic             inx;
   } lane_res_t;
endpackage

// File: rtl/hcvt_lane.sv
module hcvt_lane
   import hcvt_pkg::*;
(
   input  logic [HALF_W-1:0] half_in,
   input  rmode_e            rm,
   output lane_res_t         res
);
   localparam int EXP_W  = 5;
   localparam int FRAC_W = 10;
   localparam int FIX_W  = 40;   // 16 integer bits + 24 fraction bits
   localparam int FB     = 24;
   localparam int IP_W   = FIX_W - FB;

   logic                 sgn;
   logic [EXP_W-1:0]     ex;
   logic [FRAC_W-1:0]    fr;
   logic [FIX_W-1:0]     fix;
   logic [IP_W-1:0]      ip;
   logic [FB-1:0]        rem;
   logic                 inc;
   logic [IP_W:0]        mag;

   assign sgn = half_in[HALF_W-1];
   assign ex  = half_in[HALF_W-2 -: EXP_W];
   assign fr  = half_in[FRAC_W-1:0];

   always_comb begin
      if (ex == '0)
         fix = {{(FIX_W-FRAC_W){1'b0}}, fr};
      else
         fix = {{(FIX_W-FRAC_W-1){1'b0}}, 1'b1, fr} << (ex - 5'd1);
      ip  = fix[FIX_W-1:FB];
      rem = fix[FB-1:0];
      unique case (rm)
         RM_NEAR: inc = rem[FB-1] & ((|rem[FB-2:0]) | ip[0]);
         RM_DOWN: inc = sgn & (|rem);
         RM_UP:   inc = ~sgn & (|rem);
         default: inc = 1'b0;
      endcase
      mag = {1'b0, ip} + {{IP_W{1'b0}}, inc};

      res = '0;
      if (ex == '1) begin
         res.value = '1;
         res.inv   = 1'b1;
      end else if (sgn && (mag != '0)) begin
         res.value = '1;
         res.inv   = 1'b1;
      end else if (sgn) begin
         res.value = '0;
         res.inx   = |rem;
      end else begin
         res.value = {{(INT_W-IP_W-1){1'b0}}, mag};
         res.inx   = |rem;
      end
   end
endmodule

// File: rtl/hcvt_ctrl.sv
module hcvt_ctrl
   import hcvt_pkg::*;
#(
   parameter int MAX_LANES = 16
) (
   input  logic [1:0]           vlen_sel,
   input  logic                 bcast_rc,
   input  logic                 src_is_mem,
   input  logic [1:0]           rc_override,
   input  logic [1:0]           rc_global,
   output rmode_e               rm,
   output logic                 use_elem0,
   output logic [MAX_LANES-1:0] active
);
   localparam int CNT_W = $clog2(MAX_LANES) + 2;

   logic [CNT_W-1:0] req_cnt;
   logic [CNT_W-1:0] lane_cnt;
   logic             full_len;

   always_comb begin
      unique case (vlen_sel)
         2'd0:    req_cnt = CNT_W'(4);
         2'd1:    req_cnt = CNT_W'(8);
         default: req_cnt = CNT_W'(16);
      endcase
      lane_cnt = (req_cnt > CNT_W'(MAX_LANES)) ? CNT_W'(MAX_LANES) : req_cnt;
      full_len = (req_cnt == CNT_W'(16));
   end

   assign use_elem0 = src_is_mem & bcast_rc;
   assign rm = (!src_is_mem && full_len && bcast_rc) ? rmode_e'(rc_override)
                                                      : rmode_e'(rc_global);

   for (genvar j = 0; j < MAX_LANES; j++) begin : g_act
      assign active[j] = (CNT_W'(j) < lane_cnt);
   end
endmodule

// File: rtl/hcvt_u32_top.sv
module hcvt_u32_top
   import hcvt_pkg::*;
#(
   parameter int MAX_LANES = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [MAX_LANES*HALF_W-1:0]  src_vec,
   input  logic [MAX_LANES*INT_W-1:0]   old_dst,
   input  logic [MAX_LANES-1:0]         lane_mask,
   input  logic                         mask_en,
   input  logic                         zero_en,
   input  logic [1:0]                   vlen_sel,
   input  logic                         bcast_rc,
   input  logic                         src_is_mem,
   input  logic [1:0]                   rc_override,
   input  logic [1:0]                   rc_global,
   output logic                         out_valid,
   output logic [MAX_LANES*INT_W-1:0]   dst,
   output logic                         flag_invalid,
   output logic                         flag_inexact
);
   if (MAX_LANES != 4 && MAX_LANES != 8 && MAX_LANES != 16) begin : g_bad_lanes
      $error("MAX_LANES must be 4, 8 or 16");
   end

   rmode_e                      rm;
   logic                        use_elem0;
   logic [MAX_LANES-1:0]        active;
   logic [MAX_LANES-1:0]        wr_en;
   logic [MAX_LANES-1:0]        l_inv;
   logic [MAX_LANES-1:0]        l_inx;
   logic [MAX_LANES*INT_W-1:0]  dst_nxt;

   hcvt_ctrl #(.MAX_LANES(MAX_LANES)) u_ctrl (
      .vlen_sel    (vlen_sel),
      .bcast_rc    (bcast_rc),
      .src_is_mem  (src_is_mem),
      .rc_override (rc_override),
      .rc_global   (rc_global),
      .rm          (rm),
      .use_elem0   (use_elem0),
      .active      (active)
   );

   for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
      logic [HALF_W-1:0] h_sel;
      lane_res_t         r;

      assign h_sel = use_elem0 ? src_vec[HALF_W-1:0] : src_vec[j*HALF_W +: HALF_W];

      hcvt_lane u_lane (
         .half_in (h_sel),
         .rm      (rm),
         .res     (r)
      );

      assign wr_en[j] = active[j] & (~mask_en | lane_mask[j]);
      assign l_inv[j] = wr_en[j] & r.inv;
      assign l_inx[j] = wr_en[j] & r.inx;

      always_comb begin
         if (wr_en[j])
            dst_nxt[j*INT_W +: INT_W] = r.value;
         else if (active[j] && !zero_en)
            dst_nxt[j*INT_W +: INT_W] = old_dst[j*INT_W +: INT_W];
         else
            dst_nxt[j*INT_W +: INT_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         dst          <= '0;
         flag_invalid <= 1'b0;
         flag_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dst          <= dst_nxt;
            flag_invalid <= |l_inv;
            flag_inexact <= |l_inx;
         end
      end
   end
endmodule

// File: rtl/hcvt_chk.sv
module hcvt_chk
   import hcvt_pkg::*;
#(
   parameter int MAX_LANES = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic [MAX_LANES-1:0]        lane_mask,
   input logic                        mask_en,
   input logic                        zero_en,
   input logic [1:0]                  vlen_sel,
   input logic                        out_valid,
   input logic [MAX_LANES*INT_W-1:0]  dst,
   input logic                        flag_invalid,
   input logic                        flag_inexact
);
   logic [1:0]                 last_vlen;
   logic [MAX_LANES*INT_W-1:0] keep;
   logic                       any_ones;

   always_ff @(posedge clk) begin
      if (!rst_n)        last_vlen <= 2'd0;
      else if (in_valid) last_vlen <= vlen_sel;
   end

   always_comb begin
      int n;
      n = (last_vlen == 2'd0) ? 4 : (last_vlen == 2'd1) ? 8 : 16;
      keep     = '0;
      any_ones = 1'b0;
      for (int j = 0; j < MAX_LANES; j++) begin
         if (j < n) keep[j*INT_W +: INT_W] = '1;
         if (dst[j*INT_W +: INT_W] == '1) any_ones = 1'b1;
      end
   end

   assert_valid_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(in_valid));

   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(dst) && $stable(flag_invalid) && $stable(flag_inexact));

   assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (dst & ~keep) == '0);

   assert_invalid_gives_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flag_invalid) |-> any_ones);

   assert_zero_all_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && zero_en && lane_mask == '0)
         |=> (dst == '0) && !flag_invalid && !flag_inexact);
endmodule

bind hcvt_u32_top hcvt_chk #(.MAX_LANES(MAX_LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .lane_mask    (lane_mask),
   .mask_en      (mask_en),
   .zero_en      (zero_en),
   .vlen_sel     (vlen_sel),
   .out_valid    (out_valid),
   .dst          (dst),
   .flag_invalid (flag_invalid),
   .flag_inexact (flag_inexact)
);

// File: tb/tb_hcvt_u32_top.sv
`timescale 1ns/1ps
module tb_hcvt_u32_top;
   localparam int L  = 16;
   localparam int NV = 22;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           in_valid;
   logic [L*16-1:0] src_vec;
   logic [L*32-1:0] old_dst;
   logic [L-1:0]   lane_mask;
   logic           mask_en, zero_en, bcast_rc, src_is_mem;
   logic [1:0]     vlen_sel, rc_override, rc_global;
   logic           out_valid, flag_invalid, flag_inexact;
   logic [L*32-1:0] dst;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   hcvt_u32_top #(.MAX_LANES(L)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
      .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
      .zero_en(zero_en), .vlen_sel(vlen_sel), .bcast_rc(bcast_rc),
      .src_is_mem(src_is_mem), .rc_override(rc_override), .rc_global(rc_global),
      .out_valid(out_valid), .dst(dst), .flag_invalid(flag_invalid),
      .flag_inexact(flag_inexact)
   );

   // {half, rounding mode, expected word, invalid, inexact}
   localparam logic [51:0] VEC [0:NV-1] = '{
      {16'h3C00, 2'd0, 32'd1,        1'b0, 1'b0},
      {16'h3E00, 2'd0, 32'd2,        1'b0, 1'b1},
      {16'h4100, 2'd0, 32'd2,        1'b0, 1'b1},
      {16'h3A00, 2'd0, 32'd1,        1'b0, 1'b1},
      {16'h3800, 2'd0, 32'd0,        1'b0, 1'b1},
      {16'h7BFF, 2'd0, 32'h0000FFE0, 1'b0, 1'b0},
      {16'h3E00, 2'd1, 32'd1,        1'b0, 1'b1},
      {16'h3E00, 2'd2, 32'd2,        1'b0, 1'b1},
      {16'h3E00, 2'd3, 32'd1,        1'b0, 1'b1},
      {16'h3555, 2'd2, 32'd1,        1'b0, 1'b1},
      {16'hB800, 2'd0, 32'd0,        1'b0, 1'b1},
      {16'hB800, 2'd1, 32'hFFFFFFFF, 1'b1, 1'b0},
      {16'hB800, 2'd2, 32'd0,        1'b0, 1'b1},
      {16'hB800, 2'd3, 32'd0,        1'b0, 1'b1},
      {16'hBC00, 2'd3, 32'hFFFFFFFF, 1'b1, 1'b0},
      {16'h7C00, 2'd0, 32'hFFFFFFFF, 1'b1, 1'b0},
      {16'h7E00, 2'd3, 32'hFFFFFFFF, 1'b1, 1'b0},
      {16'hFC00, 2'd2, 32'hFFFFFFFF, 1'b1, 1'b0},
      {16'h0001, 2'd2, 32'd1,        1'b0, 1'b1},
      {16'h0001, 2'd0, 32'd0,        1'b0, 1'b1},
      {16'h8000, 2'd1, 32'd0,        1'b0, 1'b0},
      {16'h83FF, 2'd1, 32'hFFFFFFFF, 1'b1, 1'b0}
   };

   function automatic logic [L*32-1:0] rep(input logic [31:0] v, input int n);
      logic [L*32-1:0] r = '0;
      for (int j = 0; j < n; j++) r[j*32 +: 32] = v;
      return r;
   endfunction

   function automatic logic [L*16-1:0] rep_h(input logic [15:0] h);
      logic [L*16-1:0] r;
      for (int j = 0; j < L; j++) r[j*16 +: 16] = h;
      return r;
   endfunction

   task automatic check(input string req, input logic [L*32-1:0] e_dst,
                        input logic e_vld, input logic e_inv, input logic e_inx);
      n_chk++;
      if (dst !== e_dst || out_valid !== e_vld || flag_invalid !== e_inv ||
          flag_inexact !== e_inx) begin
         n_bad++;
         $display("FAIL %s: got dst=%h vld=%b inv=%b inx=%b exp dst=%h vld=%b inv=%b inx=%b",
                  req, dst, out_valid, flag_invalid, flag_inexact,
                  e_dst, e_vld, e_inv, e_inx);
      end
   endtask

   task automatic defaults();
      src_vec = '0; old_dst = '0; lane_mask = '0; mask_en = 0; zero_en = 0;
      vlen_sel = 0; bcast_rc = 0; src_is_mem = 0; rc_override = 0; rc_global = 0;
   endtask

   // drive one strobe; afterwards the registered result is visible
   task automatic fire();
      @(negedge clk) in_valid = 1'b1;
      @(negedge clk) in_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      logic [L*32-1:0] e, held;
      rst_n = 0; in_valid = 0;
      defaults();
      old_dst = '1;
      repeat (3) @(negedge clk);
      check("R12 reset", '0, 1'b0, 1'b0, 1'b0);
      rst_n = 1;

      // table walk: four lanes, all fed the same value, old contents all ones
      for (int i = 0; i < NV; i++) begin
         defaults();
         old_dst   = '1;
         src_vec   = rep_h(VEC[i][51:36]);
         rc_global = VEC[i][35:34];
         fire();
         check($sformatf("R2,R3,R9,R10,R13 vector %0d", i),
               rep(VEC[i][33:2], 4), 1'b1, VEC[i][1], VEC[i][0]);
      end

      // R4: override honoured for full-width register source
      defaults();
      src_vec = rep_h(16'h3E00); vlen_sel = 2; bcast_rc = 1;
      rc_override = 2'd2; rc_global = 2'd3;
      fire();
      check("R4 override used", rep(32'd2, 16), 1'b1, 1'b0, 1'b1);

      // R4: same bits at 8 lanes fall back to the global mode
      vlen_sel = 1;
      fire();
      check("R4 override ignored at 8 lanes", rep(32'd1, 8), 1'b1, 1'b0, 1'b1);

      // R5: memory broadcast, R4 global mode for memory source
      defaults();
      src_vec = rep_h(16'h3E00); src_vec[15:0] = 16'h4000;
      src_is_mem = 1; bcast_rc = 1; vlen_sel = 2;
      rc_override = 2'd2; rc_global = 2'd3;
      fire();
      check("R5 R4 memory broadcast", rep(32'd2, 16), 1'b1, 1'b0, 1'b0);

      // R5: register source does not broadcast
      defaults();
      src_vec = rep_h(16'h3C00); src_vec[15:0] = 16'h4000; bcast_rc = 1;
      fire();
      e = rep(32'd1, 4); e[31:0] = 32'd2;
      check("R5 no broadcast from register", e, 1'b1, 1'b0, 1'b0);

      // R6 merge
      defaults();
      for (int j = 0; j < L; j++) old_dst[j*32 +: 32] = 32'h1111_0000 + j;
      src_vec = rep_h(16'h3C00); mask_en = 1; lane_mask = 16'h0005;
      fire();
      e = '0;
      e[31:0] = 32'd1; e[63:32] = 32'h1111_0001; e[95:64] = 32'd1; e[127:96] = 32'h1111_0003;
      check("R6 merge", e, 1'b1, 1'b0, 1'b0);

      // R7 zeroing
      zero_en = 1;
      fire();
      e[63:32] = '0; e[127:96] = '0;
      check("R7 zeroing", e, 1'b1, 1'b0, 1'b0);

      // R7 all lanes masked with zeroing
      lane_mask = '0;
      fire();
      check("R7 all masked zeroed", '0, 1'b1, 1'b0, 1'b0);

      // R11 masked and inactive lanes carry infinities
      defaults();
      for (int j = 0; j < L; j++) old_dst[j*32 +: 32] = 32'h2222_0000 + j;
      src_vec = rep_h(16'h3C00);
      src_vec[31:16] = 16'h7C00; src_vec[95:80] = 16'h7C00;
      mask_en = 1; lane_mask = 16'h002D;
      fire();
      e = rep(32'd1, 4); e[63:32] = 32'h2222_0001;
      check("R11 flags from written lanes only", e, 1'b1, 1'b0, 1'b0);

      // R8 upper lanes cleared at 8 lanes
      defaults();
      old_dst = '1; src_vec = rep_h(16'h3C00); vlen_sel = 1;
      fire();
      check("R8 upper cleared", rep(32'd1, 8), 1'b1, 1'b0, 1'b0);

      // R1 code 3 behaves as 16 lanes
      vlen_sel = 3;
      fire();
      held = rep(32'd1, 16);
      check("R1 vlen code 3", held, 1'b1, 1'b0, 1'b0);

      // R12 hold without strobe
      src_vec = rep_h(16'h7C00); vlen_sel = 0; old_dst = '0;
      @(negedge clk);
      @(negedge clk);
      check("R12 hold without strobe", held, 1'b0, 1'b0, 1'b0);

      finish_run();
   end
endmodule